// File: doc/BRIEF.md
# GPIO Controller with Edge-Capture Interrupts

This block is a 28-pin general-purpose I/O peripheral sitting on a simple 32-bit register bus. Software chooses per pin whether it drives or listens, moves the output latch only through two write-one strobes (one raises bits, one lowers them), and can read the synchronized level of every pin at any time. Each pin can be armed to capture rising transitions, falling transitions or both. A captured transition sets a sticky status bit that software acknowledges by writing a one to it.

Interrupts go to a parent controller. The eleven lowest pins each get a dedicated line that follows their status bit. The remaining seventeen pins share one line that is the OR of their status bits. An extra 28-bit storage register is exported unchanged, so that pad muxing outside the block can use it.

Pin inputs pass through a two-flop synchronizer. A transition is recognised by comparing the synchronized level with its value one cycle earlier, so a status bit sets on the third rising clock edge after the pin changes.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Registers are selected by bus_addr[4:2] (bus_addr[1:0] ignored): 0x00 level (read only), 0x04 direction, 0x08 set strobe, 0x0C clear strobe, 0x10 rising enable, 0x14 falling enable, 0x18 edge status, 0x1C storage. Bit n of each is pin n. Bits 31:28 always read 0, and the set and clear strobes read as 0.
- R2: The direction register is read/write. A 1 in bit n drives pin_oe[n] high (output) and a 0 makes the pin an input.
- R3: Writing to 0x08 sets the pin_out bits that are 1 in the data. Writing to 0x0C clears them. Zero bits leave pin_out unchanged, and pin_out changes only on such writes.
- R4: A read of 0x00 returns pin_in after two synchronizer flops, whatever the direction. A change driven before rising edge k is visible after edge k+1 and not after edge k.
- R5: With its rising enable set, a 0-to-1 transition of a pin sets its status bit. With its falling enable set, a 1-to-0 transition sets it. With both set, either transition does. A transition with its enable clear records nothing. The bit becomes visible after the third rising edge following the pin change.
- R6: Status bits stay set until a 1 is written to them at 0x18. Writing 0 has no effect, and writing all ones clears every bit.
- R7: When a new transition arrives in the same cycle as a clearing write to the same status bit, the bit remains set.
- R8: irq_low[n] equals status bit n for n = 0..10, and irq_shared is the OR of status bits 27..11.
- R9: The storage register at 0x1C is read/write and its bits 27:0 appear on alt_func.
- R10: After reset, direction, pin_out, both enables, status and storage are all zero, and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 28 | Raw pin levels (asynchronous) |
| pin_out | output | 28 | Output latch |
| pin_oe | output | 28 | Output enable per pin (the direction register) |
| alt_func | output | 28 | Storage register contents |
| irq_low | output | 11 | Dedicated interrupts for pins 0..10 |
| irq_shared | output | 1 | OR of the status bits of pins 11..27 |

## Verification
The two functions that can fall in the same cycle are the capture of a new transition on a status bit and a software write-one-to-clear on that bit. The bench sets a status bit, drives a falling transition on the same pin and issues the clearing write two cycles later, so that the write lands on the edge that registers the new transition. The bit must read back as set afterwards, and a second, uncontested clear must then drop it.

// File: rtl/gpio_edge_pkg.sv
// Shared constants and register index encoding for the GPIO controller.
package gpio_edge_pkg;
    localparam int unsigned GPIO_PINS     = 28;
    localparam int unsigned GPIO_DED_IRQS = 11;
    localparam int unsigned GPIO_DATA_W   = 32;
    localparam int unsigned GPIO_ADDR_W   = 5;
    localparam int unsigned GPIO_SYNC_N   = 2;

    // Word index taken from bus_addr[4:2]; software depends on this order.
    typedef enum logic [2:0] {
        IDX_LEVEL = 3'd0,
        IDX_DIR   = 3'd1,
        IDX_SET   = 3'd2,
        IDX_CLR   = 3'd3,
        IDX_RISE  = 3'd4,
        IDX_FALL  = 3'd5,
        IDX_STAT  = 3'd6,
        IDX_ALT   = 3'd7
    } gpio_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 28,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                // Later stages shift the sample along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_reg_file.sv
// Software-written state: direction, output latch, edge enables and storage.
// Assumes one write per cycle, selected by a decoded word index.
module gpio_reg_file
    import gpio_edge_pkg::*;
#(
    parameter int unsigned WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_idx_e        wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] rise_q,
    output logic [WIDTH-1:0] fall_q,
    output logic [WIDTH-1:0] alt_q
);
    logic [WIDTH-1:0] out_d;

    // Output latch next value: set strobe raises, clear strobe lowers.
    always_comb begin
        out_d = out_q;
        if (wr_en && wr_idx == IDX_SET) out_d = out_q | wr_data;
        if (wr_en && wr_idx == IDX_CLR) out_d = out_q & ~wr_data;
    end

    // Plain read/write registers and the output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            alt_q  <= '0;
        end else begin
            out_q <= out_d;
            if (wr_en) begin
                case (wr_idx)
                    IDX_DIR:  dir_q  <= wr_data;
                    IDX_RISE: rise_q <= wr_data;
                    IDX_FALL: fall_q <= wr_data;
                    IDX_ALT:  alt_q  <= wr_data;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_edge_unit.sv
// Per-pin transition capture into sticky write-one-to-clear status bits.
// Assumes level is already synchronous. A new capture wins over a clear.
module gpio_edge_unit #(
    parameter int unsigned WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status
);
    logic [WIDTH-1:0] level_d1;
    logic [WIDTH-1:0] hit;

    // Transitions qualified by their enables.
    assign hit = (level & ~level_d1 & rise_en) | (~level & level_d1 & fall_en);

    // Delayed level and sticky status update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d1 <= '0;
            status   <= '0;
        end else begin
            level_d1 <= level;
            status   <= (status & ~clr_mask) | hit;
        end
    end
endmodule

// File: rtl/gpio_irq_map.sv
// Maps status bits to dedicated low-pin interrupts plus one shared line.
// Assumes 0 < DED < WIDTH.
module gpio_irq_map #(
    parameter int unsigned WIDTH = 28,
    parameter int unsigned DED   = 11
) (
    input  logic [WIDTH-1:0] status,
    output logic [DED-1:0]   irq_low,
    output logic             irq_shared
);
    generate
        for (genvar n = 0; n < DED; n++) begin : g_ded
            assign irq_low[n] = status[n];
        end
    endgenerate

    assign irq_shared = |status[WIDTH-1:DED];
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Top of the GPIO controller: bus decode, read mux and sub-block wiring.
// Assumes single-cycle register access; reads are combinational on bus_addr.
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int unsigned PINS   = GPIO_PINS,
    parameter int unsigned DED    = GPIO_DED_IRQS,
    parameter int unsigned DATA_W = GPIO_DATA_W,
    parameter int unsigned ADDR_W = GPIO_ADDR_W,
    parameter int unsigned SYNC_N = GPIO_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   alt_func,
    output logic [DED-1:0]    irq_low,
    output logic              irq_shared
);
    gpio_idx_e        idx;
    logic             wr_en;
    logic [PINS-1:0]  wdata_p;
    logic [PINS-1:0]  level_s;
    logic [PINS-1:0]  rise_en;
    logic [PINS-1:0]  fall_en;
    logic [PINS-1:0]  edge_status;
    logic [PINS-1:0]  stat_clr;
    logic [PINS-1:0]  rd_sel;
    logic             unused_bits;

    assign idx         = gpio_idx_e'(bus_addr[4:2]);
    assign wr_en       = bus_sel && bus_wr;
    assign wdata_p     = bus_wdata[PINS-1:0];
    assign stat_clr    = (wr_en && idx == IDX_STAT) ? wdata_p : '0;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:PINS]};

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (level_s)
    );

    gpio_reg_file #(.WIDTH(PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (wdata_p),
        .dir_q   (pin_oe),
        .out_q   (pin_out),
        .rise_q  (rise_en),
        .fall_q  (fall_en),
        .alt_q   (alt_func)
    );

    gpio_edge_unit #(.WIDTH(PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level_s),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .clr_mask (stat_clr),
        .status   (edge_status)
    );

    gpio_irq_map #(.WIDTH(PINS), .DED(DED)) u_irq (
        .status     (edge_status),
        .irq_low    (irq_low),
        .irq_shared (irq_shared)
    );

    // Read mux: strobe registers return zero.
    always_comb begin
        case (idx)
            IDX_LEVEL: rd_sel = level_s;
            IDX_DIR:   rd_sel = pin_oe;
            IDX_RISE:  rd_sel = rise_en;
            IDX_FALL:  rd_sel = fall_en;
            IDX_STAT:  rd_sel = edge_status;
            IDX_ALT:   rd_sel = alt_func;
            default:   rd_sel = '0;
        endcase
    end

    assign bus_rdata = DATA_W'(rd_sel);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
// Assertion checker for gpio_edge_ctrl, attached by bind below.
module gpio_edge_ctrl_chk #(
    parameter int unsigned PINS   = 28,
    parameter int unsigned DED    = 11,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [PINS-1:0]   pin_out,
    input logic [DED-1:0]    irq_low,
    input logic [PINS-1:0]   stat,
    input logic [PINS-1:0]   rise_en,
    input logic [PINS-1:0]   fall_en
);
    logic set_wr, clr_wr, stat_wr;
    assign set_wr  = bus_sel && bus_wr && bus_addr[4:2] == 3'd2;
    assign clr_wr  = bus_sel && bus_wr && bus_addr[4:2] == 3'd3;
    assign stat_wr = bus_sel && bus_wr && bus_addr[4:2] == 3'd6;

    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((pin_out & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));

    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((pin_out & $past(bus_wdata[PINS-1:0])) == '0));

    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_wr || clr_wr) |=> $stable(pin_out));

    p_stat_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat & $past(stat)) == $past(stat)));

    p_capture_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_low[0]) |-> $past(rise_en[0] | fall_en[0]));

    p_shared_capture_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[PINS-1]) |-> $past(rise_en[PINS-1] | fall_en[PINS-1]));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
    .PINS(PINS), .DED(DED), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .irq_low   (irq_low),
    .stat      (edge_status),
    .rise_en   (rise_en),
    .fall_en   (fall_en)
);

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [27:0] pin_in = '0;
    logic [27:0] pin_out, pin_oe, alt_func;
    logic [10:0] irq_low;
    logic        irq_shared;

    int tests = 0;
    int fails = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    gpio_edge_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_func(alt_func), .irq_low(irq_low), .irq_shared(irq_shared)
    );

    typedef struct packed {
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [31:0] rexp;
        logic [27:0] oexp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'h04, 32'hFFFF_FFFF, 5'h04, 32'h0FFF_FFFF, 28'h0000000},
        '{5'h04, 32'h0000_00F0, 5'h04, 32'h0000_00F0, 28'h0000000},
        '{5'h08, 32'h0000_0033, 5'h08, 32'h0000_0000, 28'h0000033},
        '{5'h08, 32'h0F00_0000, 5'h0C, 32'h0000_0000, 28'hF000033},
        '{5'h0C, 32'h0000_0011, 5'h08, 32'h0000_0000, 28'hF000022},
        '{5'h0C, 32'h0000_0000, 5'h04, 32'h0000_00F0, 28'hF000022},
        '{5'h1C, 32'h1234_5678, 5'h1C, 32'h0234_5678, 28'hF000022},
        '{5'h10, 32'h0800_0001, 5'h10, 32'h0800_0001, 28'hF000022},
        '{5'h14, 32'h0000_0003, 5'h14, 32'h0000_0003, 28'hF000022},
        '{5'h10, 32'h0000_0000, 5'h10, 32'h0000_0000, 28'hF000022},
        '{5'h14, 32'h0000_0000, 5'h14, 32'h0000_0000, 28'hF000022},
        '{5'h0C, 32'hFFFF_FFFF, 5'h1E, 32'h0234_5678, 28'h0000000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Write at the current negedge; returns at the next negedge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Combinational read at the current time, no clock consumed.
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(5'h04, rv); check("R10 dir", rv, 0);
        rd(5'h10, rv); check("R10 rise", rv, 0);
        rd(5'h14, rv); check("R10 fall", rv, 0);
        rd(5'h18, rv); check("R10 status", rv, 0);
        rd(5'h1C, rv); check("R10 alt", rv, 0);
        check("R10 pins", {pin_out, irq_low, irq_shared} == '0, 1);

        // R1 R2 R3 R9 register table
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd(VECS[i].ra, rv);
            check("R1 table read", rv, VECS[i].rexp);
            check("R3 table pin_out", {4'h0, pin_out}, {4'h0, VECS[i].oexp});
        end
        check("R2 pin_oe", {4'h0, pin_oe}, 32'h0000_00F0);
        check("R9 alt_func", {4'h0, alt_func}, 32'h0234_5678);

        // R4 level readback after two synchronizer flops; R5 nothing recorded with enables clear
        pin_in = 28'hA5A5A5A;
        @(negedge clk); rd(5'h00, rv); check("R4 level early", rv, 0);
        @(negedge clk); rd(5'h00, rv); check("R4 level", rv, 32'h0A5A5A5A);
        @(negedge clk); rd(5'h18, rv); check("R5 no enable", rv, 0);
        pin_in = '0;
        repeat (3) @(negedge clk);

        // R5 rising on 0, falling on 1, both on 2, rising on 20
        wr(5'h10, 32'h0010_0005);
        wr(5'h14, 32'h0000_0006);
        pin_in = 28'h0100007;
        @(negedge clk);
        @(negedge clk); rd(5'h18, rv); check("R5 not yet", rv, 0);
        @(negedge clk); rd(5'h18, rv); check("R5 rising", rv, 32'h0010_0005);
        check("R8 irq_low rise", {21'h0, irq_low}, 32'h5);
        check("R8 irq_shared rise", {31'h0, irq_shared}, 1);
        pin_in = '0;
        repeat (3) @(negedge clk);
        rd(5'h18, rv); check("R5 falling", rv, 32'h0010_0007);

        // R6 write-one-to-clear
        wr(5'h18, 32'h0); rd(5'h18, rv); check("R6 zero write", rv, 32'h0010_0007);
        wr(5'h18, 32'h0010_0000); rd(5'h18, rv); check("R6 partial", rv, 32'h7);
        check("R8 shared low", {31'h0, irq_shared}, 0);
        check("R8 irq_low", {21'h0, irq_low}, 32'h7);
        wr(5'h18, 32'hFFFF_FFFF); rd(5'h18, rv); check("R6 all ones", rv, 0);
        check("R8 irq_low clear", {21'h0, irq_low}, 0);

        // R7 capture and clear in the same cycle
        pin_in = 28'h4;
        repeat (3) @(negedge clk);
        rd(5'h18, rv); check("R7 setup", rv, 32'h4);
        pin_in = 28'h0;
        @(negedge clk);
        @(negedge clk);
        wr(5'h18, 32'h4);
        rd(5'h18, rv); check("R7 capture wins", rv, 32'h4);
        wr(5'h18, 32'h4);
        rd(5'h18, rv); check("R7 later clear", rv, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule